// File: doc/BRIEF.md
# SDRAM Cache-Line Write-Back Sequencer

This block drives an SDRAM device through the command sequence that stores one four-word cache line being written back. A write-back request carries a row, a bank, a column and the four 32-bit words of the line. The block captures all of them when it accepts the request. It then opens the row and issues four single-beat write commands on consecutive cycles. The last of these writes carries the auto-precharge flag. Each data word is driven on the data bus in the same cycle as its write command.

After the auto-precharge write, the bank is not free yet. The block first holds it through a write-recovery wait, whose length comes from a two-bit configuration input sampled at acceptance. It then holds it through a precharge wait, whose length is a two-bit elaboration parameter. Only after both waits does it drop its busy output and accept another request. Outside a burst the device is deselected.

Command pins are encoded as {cs_n, ras_n, cas_n, we_n}: deselect is 1111, activate is 0011 and write is 0100. Address bit 10 is the auto-precharge flag during a write.

Top module: `sdram_wb_burst`

## Requirements
- R1: While idle (including after reset) the command pins read 1111 (deselect), sd_dq_oe, busy and done are low.
- R2: A wb_req sampled high at a rising edge while idle produces activate (0011) in the next cycle, with wb_row on sd_addr and wb_bank on sd_ba, and busy high.
- R3: The three cycles after activate each carry write (0100) with sd_addr[10] low; the fourth cycle carries write (0100) with sd_addr[10] high (auto-precharge).
- R4: The column on sd_addr[9:0] for write k (k = 0..3) equals wb_col with its low four bits cleared, plus 4*k; address bits above the column and flag are zero.
- R5: During write k, sd_dq_out carries wb_data[32k+31:32k], sd_dq_oe is high and sd_dqm is 0000; sd_dq_oe is low in every other cycle.
- R6: After the auto-precharge write come cfg_trwl+1 recovery cycles and then TPC_SEL+1 precharge cycles, all with command 1111 and busy high; done is high only in the final precharge cycle.
- R7: busy is low in the cycle after done, and the next activate can appear no earlier than the cycle after that.
- R8: wb_req while busy is ignored. Changes to wb_row, wb_col, wb_data or cfg_trwl after acceptance do not alter the burst in progress.
- R9: sd_ba holds the accepted bank throughout the activate and all four write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wb_req | input | 1 | Write-back request, sampled while idle |
| wb_row | input | 13 | Row address |
| wb_bank | input | 2 | Bank select |
| wb_col | input | 10 | Column byte address (line-aligned internally) |
| wb_data | input | 128 | Four line words, word 0 in the low bits |
| cfg_trwl | input | 2 | Write-recovery length select, 1 to 4 cycles |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Multiplexed row/column address |
| sd_ba | output | 2 | Bank address |
| sd_dqm | output | 4 | Byte masks (0 = byte written) |
| sd_dq_out | output | 32 | Write data |
| sd_dq_oe | output | 1 | Data bus drive enable |
| busy | output | 1 | Bank locked from activate to end of precharge wait |
| done | output | 1 | Pulse in the last precharge-wait cycle |

## Verification
A corrupted state register or beat counter shows up at once on the command pins. A write appears with the wrong auto-precharge flag, the column does not step by four, or the data word does not match the command, all in the same cycle. A wrong wait counter does not change any pin during the wait; it is seen only at the end, when done and the fall of busy arrive early or late. The bench therefore checks every cycle of each burst against an independently computed length. A faulty capture path shows when inputs are disturbed mid-burst and the pins follow them.

// File: rtl/sdram_wb_pkg.sv
package sdram_wb_pkg;
  localparam int BEATS  = 4;
  localparam int STEP_B = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_WR, ST_RWL, ST_PC
  } seq_state_e;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'b1111,
    CMD_ACTV  = 4'b0011,
    CMD_WRIT  = 4'b0100
  } sd_cmd_e;

  function automatic logic [15:0] col_of_beat(input logic [15:0] base, input logic [1:0] beat);
    logic [15:0] aligned;
    aligned = base & 16'hFFF0;
    return aligned + {12'd0, beat, 2'b00};
  endfunction

  function automatic logic [2:0] wait_len(input logic [1:0] sel);
    return {1'b0, sel} + 3'd1;
  endfunction
endpackage

// File: rtl/sdram_wb_seq.sv
module sdram_wb_seq
  import sdram_wb_pkg::*;
#(
  parameter logic [1:0] TPC_SEL = 2'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  trwl_sel,
  output seq_state_e  state,
  output logic [1:0]  beat,
  output logic        accept,
  output logic        busy,
  output logic        done
);
  logic [1:0] cnt;
  logic [1:0] trwl_q;
  logic       ev_last_write;
  logic       ev_rwl_done;
  logic       ev_pc_done;

  assign accept        = (state == ST_IDLE) && req;
  assign ev_last_write = (state == ST_WR) && (beat == 2'(BEATS - 1));
  assign ev_rwl_done   = (state == ST_RWL) && (cnt == 2'd0);
  assign ev_pc_done    = (state == ST_PC) && (cnt == 2'd0);
  assign busy          = (state != ST_IDLE);
  assign done          = ev_pc_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      beat   <= 2'd0;
      cnt    <= 2'd0;
      trwl_q <= 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state  <= ST_ACT;
          trwl_q <= trwl_sel;
        end
        ST_ACT: begin
          state <= ST_WR;
          beat  <= 2'd0;
        end
        ST_WR: if (ev_last_write) begin
          state <= ST_RWL;
          cnt   <= trwl_q;
        end else begin
          beat <= beat + 2'd1;
        end
        ST_RWL: if (ev_rwl_done) begin
          state <= ST_PC;
          cnt   <= TPC_SEL;
        end else begin
          cnt <= cnt - 2'd1;
        end
        ST_PC: if (ev_pc_done) begin
          state <= ST_IDLE;
        end else begin
          cnt <= cnt - 2'd1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_accept_to_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state == ST_ACT));
  assert_last_write_to_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_write |=> (state == ST_RWL));
  assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  assert_busy_ignores_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && state != ST_PC) |=> busy);
endmodule

// File: rtl/sdram_wb_pins.sv
module sdram_wb_pins
  import sdram_wb_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DATA_W = 32,
  localparam int LINE_W = BEATS * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state,
  input  logic [1:0]        beat,
  input  logic              accept,
  input  logic [ROW_W-1:0]  row,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [LINE_W-1:0] line,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic [DATA_W/8-1:0] dqm,
  output logic [DATA_W-1:0] dq,
  output logic              dq_oe
);
  logic [ROW_W-1:0]  row_q;
  logic [BANK_W-1:0] bank_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] word_q [BEATS];
  logic [15:0]       col_now;
  logic              is_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
    end else if (accept) begin
      row_q  <= row;
      bank_q <= bank;
      col_q  <= col;
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)      word_q[g] <= '0;
      else if (accept) word_q[g] <= line[g*DATA_W +: DATA_W];
    end
  end

  assign col_now  = col_of_beat(16'(col_q), beat);
  assign is_write = (state == ST_WR);

  always_comb begin
    cmd   = CMD_DESEL;
    addr  = '0;
    ba    = '0;
    dq    = '0;
    dq_oe = 1'b0;
    dqm   = '1;
    unique case (state)
      ST_ACT: begin
        cmd  = CMD_ACTV;
        addr = ADDR_W'(row_q);
        ba   = bank_q;
      end
      ST_WR: begin
        cmd               = CMD_WRIT;
        addr[COL_W-1:0]   = col_now[COL_W-1:0];
        addr[AP_BIT]      = (beat == 2'(BEATS - 1));
        ba                = bank_q;
        dq                = word_q[beat];
        dq_oe             = 1'b1;
        dqm               = '0;
      end
      default: ;
    endcase
  end

  assert_act_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACTV) |=> (cmd == CMD_WRIT && !addr[AP_BIT]));
  assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRIT && !addr[AP_BIT]) |=>
      (cmd == CMD_WRIT && addr[COL_W-1:0] == $past(addr[COL_W-1:0]) + COL_W'(STEP_B)));
  assert_mask_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqm == '0 && cmd == CMD_WRIT));
  assert_bank_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_WRIT) |-> (ba == $past(ba)));
  always_comb begin
    if (rst_n && !is_write && state != ST_ACT)
      assert_idle_desel_R1: assert (cmd == CMD_DESEL && !dq_oe);
  end
endmodule

// File: rtl/sdram_wb_burst.sv
module sdram_wb_burst
  import sdram_wb_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int ADDR_W = 13,
  parameter int AP_BIT = 10,
  parameter int DATA_W = 32,
  parameter logic [1:0] TPC_SEL = 2'd1,
  localparam int LINE_W = BEATS * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wb_req,
  input  logic [ROW_W-1:0]    wb_row,
  input  logic [BANK_W-1:0]   wb_bank,
  input  logic [COL_W-1:0]    wb_col,
  input  logic [LINE_W-1:0]   wb_data,
  input  logic [1:0]          cfg_trwl,
  output logic                sd_cs_n,
  output logic                sd_ras_n,
  output logic                sd_cas_n,
  output logic                sd_we_n,
  output logic [ADDR_W-1:0]   sd_addr,
  output logic [BANK_W-1:0]   sd_ba,
  output logic [DATA_W/8-1:0] sd_dqm,
  output logic [DATA_W-1:0]   sd_dq_out,
  output logic                sd_dq_oe,
  output logic                busy,
  output logic                done
);
  seq_state_e state;
  logic [1:0] beat;
  logic       accept;
  logic [3:0] cmd;

  sdram_wb_seq #(.TPC_SEL(TPC_SEL)) seq_i (
    .clk(clk), .rst_n(rst_n), .req(wb_req), .trwl_sel(cfg_trwl),
    .state(state), .beat(beat), .accept(accept), .busy(busy), .done(done)
  );

  sdram_wb_pins #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W),
    .AP_BIT(AP_BIT), .DATA_W(DATA_W)
  ) pins_i (
    .clk(clk), .rst_n(rst_n), .state(state), .beat(beat), .accept(accept),
    .row(wb_row), .bank(wb_bank), .col(wb_col), .line(wb_data),
    .cmd(cmd), .addr(sd_addr), .ba(sd_ba), .dqm(sd_dqm),
    .dq(sd_dq_out), .dq_oe(sd_dq_oe)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  assert_busy_covers_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sd_cs_n |-> busy);
  assert_done_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy && sd_cs_n && !sd_dq_oe));
endmodule

// File: tb/sdram_wb_burst_tb.sv
module sdram_wb_burst_tb_top;
  localparam int TPC = 1;
  localparam int NV  = 4;
  // {row[58:46], bank[45:44], col[43:34], trwl[33:32], seed[31:0]}
  localparam logic [58:0] VEC [NV] = '{
    {13'h0123, 2'd0, 10'h000, 2'd0, 32'h1111_0000},
    {13'h1FFF, 2'd3, 10'h3F7, 2'd3, 32'hA5A5_5A5A},
    {13'h0A0A, 2'd1, 10'h12C, 2'd1, 32'hDEAD_BEEF},
    {13'h1000, 2'd2, 10'h0F0, 2'd2, 32'h0000_0001}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wb_req = 1'b0;
  logic [12:0]  wb_row = '0;
  logic [1:0]   wb_bank = '0;
  logic [9:0]   wb_col = '0;
  logic [127:0] wb_data = '0;
  logic [1:0]   cfg_trwl = '0;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe, busy, done;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sdram_wb_burst #(.TPC_SEL(2'(TPC))) dut_i (
    .clk(clk), .rst_n(rst_n), .wb_req(wb_req), .wb_row(wb_row), .wb_bank(wb_bank),
    .wb_col(wb_col), .wb_data(wb_data), .cfg_trwl(cfg_trwl),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .busy(busy), .done(done)
  );

  function automatic logic [3:0] pins();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  function automatic logic [31:0] word_k(input logic [31:0] seed, input int k);
    return seed ^ (32'h0101_0101 * k) ^ (k << 28);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_chk(input string req);
    chk(pins() == 4'b1111, req, 64'(pins()), 64'hF);
    chk(!busy && !done && !sd_dq_oe, req, {61'd0, busy, done, sd_dq_oe}, 64'd0);
  endtask

  // Runs one burst; disturb changes inputs after acceptance (R8), hold keeps wb_req high.
  task automatic burst(input logic [12:0] row, input logic [1:0] bank, input logic [9:0] col,
                       input logic [1:0] trwl, input logic [31:0] seed, input bit disturb);
    int waits;
    logic [9:0] ec;
    wb_row = row; wb_bank = bank; wb_col = col; cfg_trwl = trwl;
    for (int k = 0; k < 4; k++) wb_data[k*32 +: 32] = word_k(seed, k);
    wb_req = 1'b1;
    @(negedge clk);
    if (!disturb) wb_req = 1'b0;
    chk(pins() == 4'b0011, "R2 act", 64'(pins()), 64'h3);
    chk(sd_addr == row && sd_ba == bank && busy, "R2 row/bank",
        {sd_addr, sd_ba, busy}, {row, bank, 1'b1});
    if (disturb) begin
      wb_row = ~row; wb_bank = ~bank; wb_col = ~col; cfg_trwl = ~trwl; wb_data = ~wb_data;
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ec = (col & 10'h3F0) + 10'(4 * k);
      chk(pins() == 4'b0100, "R3 write cmd", 64'(pins()), 64'h4);
      chk(sd_addr[10] == (k == 3), "R3 autoprecharge flag", 64'(sd_addr[10]), 64'(k == 3));
      chk(sd_addr[9:0] == ec && sd_addr[12:11] == 2'd0, "R4 column", 64'(sd_addr), 64'(ec));
      chk(sd_dq_out == word_k(seed, k) && sd_dq_oe && sd_dqm == 4'd0, "R5 data",
          {sd_dq_out, sd_dqm, sd_dq_oe}, {word_k(seed, k), 4'd0, 1'b1});
      chk(sd_ba == bank, "R9 bank held", 64'(sd_ba), 64'(bank));
    end
    waits = (int'(trwl) + 1) + (TPC + 1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk(pins() == 4'b1111 && busy && !sd_dq_oe, "R6 wait pins", {pins(), busy, sd_dq_oe},
          {4'hF, 1'b1, 1'b0});
      chk(done == (i == waits - 1), "R6 done position", 64'(done), 64'(i == waits - 1));
    end
    @(negedge clk);
    chk(!busy, "R7 busy release", 64'(busy), 64'd0);
    idle_chk("R1 between bursts");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_chk("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 after reset");

    for (int v = 0; v < NV; v++)
      burst(VEC[v][58:46], VEC[v][45:44], VEC[v][43:34], VEC[v][33:32], VEC[v][31:0], 1'b0);

    // R8: request held and inputs disturbed during the burst
    burst(13'h0777, 2'd1, 10'h01A, 2'd2, 32'h0F0F_F0F0, 1'b1);
    @(negedge clk);
    chk(pins() == 4'b0011, "R7 earliest next activate", 64'(pins()), 64'h3);
    chk(sd_addr == ~13'h0777, "R8 new request uses new row", 64'(sd_addr), 64'(~13'h0777));
    wb_req = 1'b0;
    for (int i = 0; i < 40 && !done; i++) @(negedge clk);
    @(negedge clk);
    idle_chk("R1 after held request");

    // R8: request held through reset is ignored until reset ends
    wb_req = 1'b1; rst_n = 1'b0;
    @(negedge clk);
    idle_chk("R1 request under reset");
    wb_req = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    idle_chk("R1 no request");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule